// File: doc/BRIEF.md
# Tick-Driven Countdown Timers with Elapsed-Time Alarm

This block keeps time from a slow tick enable, nominally 32.768 kHz, that pulses for one cycle of the fast system clock. It holds two independent 24-bit countdown timers. Each one reloads itself and raises a periodic interrupt. It also holds a 48-bit free-running elapsed-time counter that is compared against a 48-bit alarm value. At the 32.768 kHz rate a 24-bit period reaches 512 seconds, and the 48-bit counter wraps after about 272 years.

Software reaches the block through a small synchronous register port with 16-bit data. Through it software sets each timer's reload value, starts and stops the timers, reads and writes the elapsed counter and the alarm value in 16-bit parts, and clears sticky interrupt flags by writing ones. Read data appears on `rdata` in the cycle after the read strobe. A read of the counter's low part captures the upper 32 bits, so that the following middle and high reads return a coherent value.

Top module: `rtc_timer_core`

## Requirements
- R1: While a timer runs, its count falls by one on every tick. After a start it expires on the Nth tick, where N is its reload value. Starting means writing its control bit from 0 to 1, which loads the reload value.
- R2: On expiry a timer reloads on that same tick and sets its sticky flag, so it expires again every N ticks. The two timers run independently. Timer 0 drives `irq_timer[0]` and timer 1 drives `irq_timer[1]`.
- R3: The status register (address 5) holds timer0 at bit 0, timer1 at bit 1 and alarm at bit 2. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. A flag stays set until it is cleared. If a new event and a clear arrive in the same cycle, the event wins.
- R4: A timer whose reload value is 0 never expires, even while its run bit is set.
- R5: The elapsed counter rises by one per tick and wraps from all ones to zero.
- R6: The alarm flag is set on the tick that advances the elapsed counter to the compare value.
- R7: Reading the counter's low part (address 6) returns the live low 16 bits and captures the middle and high parts. Reads of address 7 and address 8 return that captured copy.
- R8: After reset, all counts, reload values, compare bits, run bits and flags are zero, and every interrupt output is low.
- R9: Register map:
  - 0 and 1 hold timer 0's reload value, bits 15:0 and 23:16.
  - 2 and 3 hold timer 1's reload value in the same split.
  - 4 is control: run bit of timer 0 at bit 0, timer 1 at bit 1.
  - 5 is status.
  - 6, 7 and 8 are the counter's low, middle and high parts.
  - 9, 10 and 11 are the compare value's low, middle and high parts.
- R10: A write to a counter part replaces those 16 bits. If a tick arrives in the same cycle, the write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle 32.768 kHz time-base enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after `rd_en` |
| irq_timer | output | 2 | Sticky expiry flags of the two timers |
| irq_alarm | output | 1 | Sticky alarm flag |

## Verification
The assertions assume that `tick` is a single-cycle pulse. They also assume that `wr_en` and `rd_en` only name the defined addresses, and that reset is applied before the first strobe. The bench drives every strobe for exactly one clock, between falling edges, and uses only addresses 0 to 11. It never asserts a tick together with a write, except in the one case where that collision is the subject of the check.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int TMR_W = 24;
    localparam int ET_W  = 48;
    localparam int REG_W = 16;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_T0_LO  = 4'd0;
    localparam logic [ADDR_W-1:0] A_T0_HI  = 4'd1;
    localparam logic [ADDR_W-1:0] A_T1_LO  = 4'd2;
    localparam logic [ADDR_W-1:0] A_T1_HI  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd4;
    localparam logic [ADDR_W-1:0] A_STAT   = 4'd5;
    localparam logic [ADDR_W-1:0] A_ET_LO  = 4'd6;
    localparam logic [ADDR_W-1:0] A_ET_MI  = 4'd7;
    localparam logic [ADDR_W-1:0] A_ET_HI  = 4'd8;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 4'd9;
    localparam logic [ADDR_W-1:0] A_CMP_MI = 4'd10;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 4'd11;
endpackage

// File: rtl/rtc_countdown.sv
module rtc_countdown #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         start,
    input  logic [W-1:0] reload,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (start) begin
            cnt_d = reload;
        end else if (tick && run) begin
            if (cnt_q <= W'(1)) begin
                cnt_d  = reload;
                expire = (cnt_q == W'(1));
            end else begin
                cnt_d = cnt_q - W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R1: a running count above one steps down by exactly one per tick
    p_step_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && run && !start && cnt_q > W'(1)) |=> (cnt_q == $past(cnt_q) - W'(1)));

    // R2: after an expiry the count holds the reload value
    p_reload_on_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == $past(reload)));

    // R4: a zero count with zero reload cannot expire
    p_zero_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reload == '0 && cnt_q == '0 && !start) |=> (cnt_q == '0));
endmodule

// File: rtl/rtc_elapsed.sv
module rtc_elapsed #(
    parameter int EW = 48,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [RW-1:0] wr_data,
    input  logic [EW-1:0] cmp,
    output logic [EW-1:0] cnt,
    output logic          alarm
);
    localparam int PARTS = EW / RW;

    logic [EW-1:0] cnt_d, cnt_q;
    logic [EW-1:0] cnt_inc;

    assign cnt_inc = cnt_q + EW'(1);

    always_comb begin
        cnt_d = cnt_q;
        alarm = 1'b0;
        if (wr_en) begin
            if (int'(wr_sel) < PARTS) cnt_d[int'(wr_sel)*RW +: RW] = wr_data;
        end else if (tick) begin
            cnt_d = cnt_inc;
            alarm = (cnt_inc == cmp);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    // R5: an undisturbed tick advances the counter by one, wrapping at the top
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en) |=> (cnt_q == $past(cnt_q) + EW'(1)));

    // R5: without tick or write the counter holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/rtc_timer_core.sv
module rtc_timer_core
    import rtc_pkg::*;
#(
    parameter int TW = TMR_W,
    parameter int EW = ET_W,
    parameter int RW = REG_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [RW-1:0] wdata,
    output logic [RW-1:0] rdata,
    output logic [1:0]    irq_timer,
    output logic          irq_alarm
);
    localparam int NT   = 2;
    localparam int HI_W = TW - RW;
    localparam int NF   = NT + 1;
    localparam int SH_W = EW - RW;

    typedef struct packed {
        logic [NT-1:0][TW-1:0] reload;
        logic [NT-1:0]         run;
        logic [NF-1:0]         flags;
        logic [EW-1:0]         cmp;
        logic [SH_W-1:0]       shadow;
        logic [RW-1:0]         rdata;
    } state_t;

    state_t        s_d, s_q;
    logic [NT-1:0] start;
    logic [NT-1:0] expire;
    logic          alarm;
    logic [EW-1:0] et_cnt;
    logic          et_wr;
    logic [1:0]    et_sel;
    logic          stat_clr_any;

    assign et_wr  = wr_en && (addr == A_ET_LO || addr == A_ET_MI || addr == A_ET_HI);
    assign et_sel = 2'(addr - A_ET_LO);

    always_comb begin
        s_d   = s_q;
        start = '0;
        if (wr_en) begin
            case (addr)
                A_T0_LO:  s_d.reload[0][RW-1:0]  = wdata;
                A_T0_HI:  s_d.reload[0][TW-1:RW] = wdata[HI_W-1:0];
                A_T1_LO:  s_d.reload[1][RW-1:0]  = wdata;
                A_T1_HI:  s_d.reload[1][TW-1:RW] = wdata[HI_W-1:0];
                A_CTRL: begin
                    s_d.run = wdata[NT-1:0];
                    start   = wdata[NT-1:0] & ~s_q.run;
                end
                A_STAT:   s_d.flags = s_q.flags & ~wdata[NF-1:0];
                A_CMP_LO: s_d.cmp[RW-1:0]      = wdata;
                A_CMP_MI: s_d.cmp[2*RW-1:RW]   = wdata;
                A_CMP_HI: s_d.cmp[EW-1:2*RW]   = wdata;
                default: ;
            endcase
        end
        s_d.flags = s_d.flags | {alarm, expire};
        if (rd_en) begin
            case (addr)
                A_T0_LO:  s_d.rdata = s_q.reload[0][RW-1:0];
                A_T0_HI:  s_d.rdata = RW'(s_q.reload[0][TW-1:RW]);
                A_T1_LO:  s_d.rdata = s_q.reload[1][RW-1:0];
                A_T1_HI:  s_d.rdata = RW'(s_q.reload[1][TW-1:RW]);
                A_CTRL:   s_d.rdata = RW'(s_q.run);
                A_STAT:   s_d.rdata = RW'(s_q.flags);
                A_ET_LO: begin
                    s_d.rdata  = et_cnt[RW-1:0];
                    s_d.shadow = et_cnt[EW-1:RW];
                end
                A_ET_MI:  s_d.rdata = s_q.shadow[RW-1:0];
                A_ET_HI:  s_d.rdata = s_q.shadow[SH_W-1:RW];
                A_CMP_LO: s_d.rdata = s_q.cmp[RW-1:0];
                A_CMP_MI: s_d.rdata = s_q.cmp[2*RW-1:RW];
                A_CMP_HI: s_d.rdata = s_q.cmp[EW-1:2*RW];
                default:  s_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        for (genvar i = 0; i < NT; i++) begin : g_tmr
            rtc_countdown #(.W(TW)) u_tmr (
                .clk    (clk),
                .rst_n  (rst_n),
                .tick   (tick),
                .run    (s_q.run[i]),
                .start  (start[i]),
                .reload (s_q.reload[i]),
                .expire (expire[i])
            );
        end
    endgenerate

    rtc_elapsed #(.EW(EW), .RW(RW)) u_et (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .wr_en   (et_wr),
        .wr_sel  (et_sel),
        .wr_data (wdata),
        .cmp     (s_q.cmp),
        .cnt     (et_cnt),
        .alarm   (alarm)
    );

    assign rdata     = s_q.rdata;
    assign irq_timer = s_q.flags[NT-1:0];
    assign irq_alarm = s_q.flags[NT];

    assign stat_clr_any = wr_en && (addr == A_STAT);

    // R3: a set flag survives any cycle that does not clear it
    p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_alarm && !(stat_clr_any && wdata[NT])) |=> irq_alarm);

    // R3: an event in the same cycle as a clear still leaves the flag set
    p_event_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        expire[0] |=> irq_timer[0]);

    // R6: when the alarm fires, the counter now equals the compare value
    p_alarm_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm && !(wr_en && (addr == A_CMP_LO || addr == A_CMP_MI || addr == A_CMP_HI)))
        |=> (et_cnt == s_q.cmp));

    // R4: a timer with zero reload never produces an expiry
    p_no_expire_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.reload[1] == '0) |-> !expire[1]);
endmodule

// File: tb/tb_rtc_timer_core.sv
module tb_rtc_timer_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  irq_timer;
    logic        irq_alarm;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rtc_timer_core dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_timer(irq_timer), .irq_alarm(irq_alarm)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic wr_with_tick(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; tick = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic t_reset;
        logic [15:0] v;
        check("R8 irq_timer", 16'(irq_timer), 16'h0);
        check("R8 irq_alarm", 16'(irq_alarm), 16'h0);
        rd(4'd5, v); check("R8 status", v, 16'h0);
        rd(4'd6, v); check("R8 counter low", v, 16'h0);
        rd(4'd9, v); check("R8 compare low", v, 16'h0);
    endtask

    task automatic t_period;
        wr(4'd0, 16'd3);
        wr(4'd4, 16'h1);
        ticks(2);
        check("R1 no expiry before N ticks", 16'(irq_timer), 16'h0);
        ticks(1);
        check("R1 expiry on tick N", 16'(irq_timer), 16'h1);
        wr(4'd5, 16'h0);
        check("R3 write 0 keeps flag", 16'(irq_timer), 16'h1);
        wr(4'd5, 16'h1);
        check("R3 write 1 clears flag", 16'(irq_timer), 16'h0);
        ticks(2);
        check("R2 no early reexpiry", 16'(irq_timer), 16'h0);
        ticks(1);
        check("R2 periodic reexpiry", 16'(irq_timer), 16'h1);
        wr(4'd5, 16'h1);
    endtask

    task automatic t_two_timers;
        wr(4'd4, 16'h0);
        wr(4'd0, 16'd2);
        wr(4'd2, 16'd5);
        wr(4'd5, 16'h7);
        wr(4'd4, 16'h3);
        ticks(2);
        check("R2 timer0 alone", 16'(irq_timer), 16'h1);
        ticks(2);
        check("R2 timer1 still pending", 16'(irq_timer), 16'h1);
        ticks(1);
        check("R2 timer1 expires independently", 16'(irq_timer), 16'h3);
        wr(4'd4, 16'h0);
        wr(4'd3, 16'h1);
        wr(4'd2, 16'h0);
        wr(4'd5, 16'h7);
        wr(4'd4, 16'h2);
        ticks(6);
        check("R9 high reload part lengthens timer1", 16'(irq_timer), 16'h0);
    endtask

    task automatic t_zero_reload;
        wr(4'd4, 16'h0);
        wr(4'd0, 16'h0);
        wr(4'd5, 16'h7);
        wr(4'd4, 16'h1);
        ticks(8);
        check("R4 zero reload never expires", 16'(irq_timer), 16'h0);
        wr(4'd4, 16'h0);
    endtask

    task automatic t_elapsed;
        logic [15:0] v;
        wr(4'd6, 16'hFFFF); wr(4'd7, 16'hFFFF); wr(4'd8, 16'hFFFF);
        rd(4'd6, v); check("R10 write loads low", v, 16'hFFFF);
        ticks(1);
        rd(4'd6, v); check("R5 wrap low", v, 16'h0);
        rd(4'd7, v); check("R5 wrap mid", v, 16'h0);
        rd(4'd8, v); check("R5 wrap high", v, 16'h0);
        ticks(7);
        rd(4'd6, v); check("R5 counts ticks", v, 16'd7);
        wr_with_tick(4'd6, 16'h0020);
        rd(4'd6, v); check("R10 write wins over tick", v, 16'h0020);
    endtask

    task automatic t_alarm;
        wr(4'd6, 16'd7); wr(4'd7, 16'h0); wr(4'd8, 16'h0);
        wr(4'd5, 16'h7);
        wr(4'd9, 16'd10);
        ticks(2);
        check("R6 no alarm before match", 16'(irq_alarm), 16'h0);
        ticks(1);
        check("R6 alarm at match", 16'(irq_alarm), 16'h1);
        ticks(1);
        check("R3 alarm stays set", 16'(irq_alarm), 16'h1);
        wr(4'd5, 16'h4);
        check("R3 alarm cleared", 16'(irq_alarm), 16'h0);
    endtask

    task automatic t_snapshot;
        logic [15:0] v;
        wr(4'd6, 16'hFFFE); wr(4'd7, 16'h1234); wr(4'd8, 16'hABCD);
        rd(4'd6, v); check("R7 live low", v, 16'hFFFE);
        ticks(2);
        rd(4'd7, v); check("R7 captured mid", v, 16'h1234);
        rd(4'd8, v); check("R7 captured high", v, 16'hABCD);
        rd(4'd6, v); check("R7 new low", v, 16'h0000);
        rd(4'd7, v); check("R7 new mid", v, 16'h1235);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period();
        t_two_timers();
        t_zero_reload();
        t_elapsed();
        t_alarm();
        t_snapshot();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule